// File: doc/BRIEF.md
# Processor Interrupt Pin Front-End

This block sits between a processor core's external control pins and the core. It turns those pins into internal requests. Seven pins come in:

- time-base enable
- external interrupt
- system-management interrupt
- machine check
- checkstop (active low)
- hard reset (active low)
- soft reset

Every pin first passes through a multi-flop synchronizer. The block then compares the synchronized level with a registered copy of the last level it processed. A pin only does something in the cycle its synchronized level actually changes, so a pin that is held at a level never produces a repeated event.

Each pin has its own sensitivity:

| Pin kind | Effect |
|---|---|
| Interrupt-style level pins (external, system-management, soft reset) | Their pending bit takes the new level. |
| Machine check | A falling edge latches its pending bit. |
| Checkstop | A falling edge sets a sticky core-stop flag that only reset releases. |
| Hard reset | A falling edge fires a one-cycle system-reset request. |
| Time-base enable | Its level becomes the run/freeze control for the time base. |

The core reads a four-bit pending vector and a combined hard-interrupt request. It acknowledges bits through a per-bit clear port, which takes effect at the next clock edge.

Top module: `cpu_pin_frontend`

## Requirements
- R1: While `rst_n` is low, the outputs are `pending` = 0, `hard_irq` = 0, `tb_run` = 1, `core_stop` = 0 and `sys_reset_req` = 0. The synchronizer and the stored levels are also reset, to the idle levels (time-base enable 1, checkstop 1, hard reset 1, all other pins 0).
- R2: `tb_run` takes the level of `pin_tb_run`. The level is sampled SYNC_STAGES rising edges earlier and takes effect on the next edge, so with the default of 2 stages a pin change shows on the third rising edge. High means run and low means freeze.
- R3: Pending bit 0 (external interrupt) follows `pin_ext_irq` and pending bit 1 (system management) follows `pin_smi`. When the synchronized level changes, the bit is set on a rise and cleared on a fall.
- R4: Pending bit 2 is set by a falling edge of the synchronized `pin_mchk`. A rising edge leaves it unchanged.
- R5: A falling edge of the synchronized `pin_ckstop_n` sets `core_stop`. Once set, it stays set until `rst_n` is asserted, whatever the pin does afterwards.
- R6: A falling edge of the synchronized `pin_hreset_n` makes `sys_reset_req` high for exactly one cycle. A rising edge produces nothing.
- R7: Pending bit 3 (reset interrupt) follows the level of `pin_sreset` when the synchronized level changes.
- R8: `hard_irq` is high exactly when at least one pending bit is set.
- R9: A 1 on `pend_ack[b]` clears pending bit b at the next rising edge. If a pin event that sets bit b happens at the same edge, the event wins. A cleared bit is not set again while its pin holds a steady level.
- R10: An event is generated only when a pin's synchronized level differs from its stored copy. A pin held at an active level produces a single event. A pulse that lasts one clock is still seen as both a rise and a fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_tb_run | input | 1 | Time-base enable pin, active high |
| pin_ext_irq | input | 1 | External interrupt pin, level, active high |
| pin_smi | input | 1 | System-management interrupt pin, level, active high |
| pin_mchk | input | 1 | Machine-check pin, falling-edge sensitive |
| pin_ckstop_n | input | 1 | Checkstop pin, active low |
| pin_hreset_n | input | 1 | Hard-reset pin, active low |
| pin_sreset | input | 1 | Soft-reset pin, level, active high |
| pend_ack | input | 4 | Per-bit acknowledge-clear from the core |
| pending | output | 4 | Pending vector: bit 0 ext, 1 smi, 2 mchk, 3 soft reset |
| hard_irq | output | 1 | OR of all pending bits |
| tb_run | output | 1 | Time-base run (1) or freeze (0) |
| core_stop | output | 1 | Sticky core-stop flag |
| sys_reset_req | output | 1 | One-cycle system-reset request |

## Verification
Directed pin sequences come first:

- Slow toggles of each level pin separate correct level tracking from wrong bit mapping or polarity.
- Single-cycle glitches and held-low pins on the machine-check, hard-reset and checkstop inputs separate edge sensitivity from level sensitivity. They also separate one-shot behaviour from repeated firing.
- Acknowledges issued while a pin stays high, and at the same edge as a machine-check fall, decide between clear-wins and event-wins ordering.

A long pseudo-random phase then toggles pins and acknowledges together. This exposes latency and ordering errors that the directed cases miss. A reset in the middle of the run shows that the sticky stop flag is released only by reset.

// File: rtl/pinfe_pkg.sv
package pinfe_pkg;

   // pin vector layout inside the block
   localparam int PIN_TB      = 0;
   localparam int PIN_EXT     = 1;
   localparam int PIN_SMI     = 2;
   localparam int PIN_MCHK    = 3;
   localparam int PIN_CKSTOP  = 4;
   localparam int PIN_HRESET  = 5;
   localparam int PIN_SRESET  = 6;
   localparam int PIN_COUNT   = 7;

   // pending vector layout seen by the core
   localparam int PND_EXT     = 0;
   localparam int PND_SMI     = 1;
   localparam int PND_MCHK    = 2;
   localparam int PND_SRST    = 3;
   localparam int PND_COUNT   = 4;

   typedef enum logic [1:0] {
      SENSE_LEVEL   = 2'd0,   // bit copies the new level
      SENSE_FALL    = 2'd1    // bit latched on a falling edge only
   } sense_e;

   function automatic int pnd_source(input int b);
      case (b)
         PND_EXT:  return PIN_EXT;
         PND_SMI:  return PIN_SMI;
         PND_MCHK: return PIN_MCHK;
         default:  return PIN_SRESET;
      endcase
   endfunction

   function automatic sense_e pnd_sense(input int b);
      return (b == PND_MCHK) ? SENSE_FALL : SENSE_LEVEL;
   endfunction

endpackage

// File: rtl/pinfe_sync.sv
module pinfe_sync #(
   parameter int               W      = 7,
   parameter int               STAGES = 2,
   parameter logic [W-1:0]     IDLE   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= IDLE;
      else        stg[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[k] <= IDLE;
         else        stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pinfe_change.sv
module pinfe_change #(
   parameter int           W    = 7,
   parameter logic [W-1:0] IDLE = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   output logic [W-1:0] chg
);

   logic [W-1:0] seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= IDLE;
      else        seen <= lvl;
   end

   assign chg = lvl ^ seen;

endmodule

// File: rtl/pinfe_pending.sv
module pinfe_pending #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_v,
   input  logic [W-1:0] drop_v,
   input  logic [W-1:0] ack,
   output logic [W-1:0] pend
);

   logic [W-1:0] pend_q;

   // a setting event outranks both acknowledge and level drop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~ack & ~drop_v) | set_v;
   end

   assign pend = pend_q;

endmodule

// File: rtl/pinfe_ctrl.sv
module pinfe_ctrl #(
   parameter logic TB_RST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tb_chg,
   input  logic tb_lvl,
   input  logic stop_fall,
   input  logic hrst_fall,
   output logic tb_run,
   output logic stopped,
   output logic rst_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tb_run  <= TB_RST;
         stopped <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         if (tb_chg)    tb_run  <= tb_lvl;
         if (stop_fall) stopped <= 1'b1;
         rst_req <= hrst_fall;
      end
   end

endmodule

// File: rtl/cpu_pin_frontend.sv
module cpu_pin_frontend
   import pinfe_pkg::*;
#(
   parameter int   SYNC_STAGES = 2,
   parameter logic TB_RUN_RST  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pin_tb_run,
   input  logic                 pin_ext_irq,
   input  logic                 pin_smi,
   input  logic                 pin_mchk,
   input  logic                 pin_ckstop_n,
   input  logic                 pin_hreset_n,
   input  logic                 pin_sreset,
   input  logic [PND_COUNT-1:0] pend_ack,
   output logic [PND_COUNT-1:0] pending,
   output logic                 hard_irq,
   output logic                 tb_run,
   output logic                 core_stop,
   output logic                 sys_reset_req
);

   // idle levels: active-low pins rest high, time base rests at its reset state
   localparam logic [PIN_COUNT-1:0] IDLE_LV =
      {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, TB_RUN_RST};

   if (SYNC_STAGES < 1 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 1..4");
   end

   logic [PIN_COUNT-1:0] raw, lvl, chg;
   logic [PND_COUNT-1:0] set_v, drop_v;

   assign raw[PIN_TB]     = pin_tb_run;
   assign raw[PIN_EXT]    = pin_ext_irq;
   assign raw[PIN_SMI]    = pin_smi;
   assign raw[PIN_MCHK]   = pin_mchk;
   assign raw[PIN_CKSTOP] = pin_ckstop_n;
   assign raw[PIN_HRESET] = pin_hreset_n;
   assign raw[PIN_SRESET] = pin_sreset;

   pinfe_sync #(.W(PIN_COUNT), .STAGES(SYNC_STAGES), .IDLE(IDLE_LV)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl));

   pinfe_change #(.W(PIN_COUNT), .IDLE(IDLE_LV)) u_chg (
      .clk(clk), .rst_n(rst_n), .lvl(lvl), .chg(chg));

   for (genvar b = 0; b < PND_COUNT; b++) begin : g_pnd
      localparam int SRC = pnd_source(b);
      if (pnd_sense(b) == SENSE_FALL) begin : g_fall
         assign set_v[b]  = chg[SRC] & ~lvl[SRC];
         assign drop_v[b] = 1'b0;
      end else begin : g_level
         assign set_v[b]  = chg[SRC] &  lvl[SRC];
         assign drop_v[b] = chg[SRC] & ~lvl[SRC];
      end
   end

   pinfe_pending #(.W(PND_COUNT)) u_pend (
      .clk(clk), .rst_n(rst_n), .set_v(set_v), .drop_v(drop_v),
      .ack(pend_ack), .pend(pending));

   pinfe_ctrl #(.TB_RST(TB_RUN_RST)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .tb_chg(chg[PIN_TB]), .tb_lvl(lvl[PIN_TB]),
      .stop_fall(chg[PIN_CKSTOP] & ~lvl[PIN_CKSTOP]),
      .hrst_fall(chg[PIN_HRESET] & ~lvl[PIN_HRESET]),
      .tb_run(tb_run), .stopped(core_stop), .rst_req(sys_reset_req));

   assign hard_irq = |pending;

endmodule

// File: rtl/pinfe_checker.sv
module pinfe_checker #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       pin_tb_run,
   input logic       pin_ext_irq,
   input logic       pin_mchk,
   input logic [3:0] pend_ack,
   input logic [3:0] pending,
   input logic       tb_run,
   input logic       core_stop,
   input logic       sys_reset_req
);

   localparam int LAT = SYNC_STAGES + 1;

   logic [2:0] since_rst;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
   end
   wire warm = (since_rst > 3'(LAT));

   // R4: machine-check bit is not dropped without an acknowledge
   p_mchk_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[2] && !pend_ack[2]) |=> pending[2]);

   // R5: core stop never releases while out of reset
   p_stop_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      core_stop |=> core_stop);

   // R6: reset request lasts a single cycle
   p_rstreq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |=> !sys_reset_req);

   // R3: a low external pin leaves its pending bit clear after the latency
   p_ext_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && !$past(pin_ext_irq, LAT)) |-> !pending[0]);

   // R2: run control tracks the pin delayed by the latency
   p_tb_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
      warm |-> (tb_run == $past(pin_tb_run, LAT)));

   // R9: acknowledge with no machine-check fall clears the bit
   p_ack_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (warm && $past(pend_ack[2]) && $past(pin_mchk, LAT)) |-> !pending[2]);

endmodule

bind cpu_pin_frontend pinfe_checker #(.SYNC_STAGES(SYNC_STAGES)) u_pinfe_chk (
   .clk(clk), .rst_n(rst_n), .pin_tb_run(pin_tb_run),
   .pin_ext_irq(pin_ext_irq), .pin_mchk(pin_mchk), .pend_ack(pend_ack),
   .pending(pending), .tb_run(tb_run), .core_stop(core_stop),
   .sys_reset_req(sys_reset_req));

// File: tb/cpu_pin_frontend_test.sv
`timescale 1ns/1ps
module cpu_pin_frontend_test;

   localparam int STG = 2;
   // pin vector: 0 tb, 1 ext, 2 smi, 3 mchk, 4 ckstop_n, 5 hreset_n, 6 sreset
   localparam logic [6:0] IDLE = 7'b0110001;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [6:0] pins = IDLE;
   logic [3:0] ack = '0;
   logic [3:0] pending;
   logic       hard_irq, tb_run, core_stop, sys_reset_req;

   int checks = 0;
   int bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cpu_pin_frontend #(.SYNC_STAGES(STG)) uut (
      .clk(clk), .rst_n(rst_n),
      .pin_tb_run(pins[0]), .pin_ext_irq(pins[1]), .pin_smi(pins[2]),
      .pin_mchk(pins[3]), .pin_ckstop_n(pins[4]), .pin_hreset_n(pins[5]),
      .pin_sreset(pins[6]), .pend_ack(ack), .pending(pending),
      .hard_irq(hard_irq), .tb_run(tb_run), .core_stop(core_stop),
      .sys_reset_req(sys_reset_req));

   // reference model: history of sampled pins, behavioural update per edge
   logic [6:0] hist [$];
   logic [3:0] m_pend;
   logic       m_tb, m_stop, m_req;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist = {};
         for (int i = 0; i < STG + 2; i++) hist.push_front(IDLE);
         m_pend = '0; m_tb = 1'b1; m_stop = 1'b0; m_req = 1'b0;
      end else begin
         logic [6:0] nw, od;
         hist.push_front(pins);
         while (hist.size() > STG + 3) void'(hist.pop_back());
         nw = hist[STG];
         od = hist[STG+1];
         m_req = 1'b0;
         m_pend = m_pend & ~ack;
         if (nw[1] != od[1]) m_pend[0] = nw[1];
         if (nw[2] != od[2]) m_pend[1] = nw[2];
         if (od[3] && !nw[3]) m_pend[2] = 1'b1;
         if (nw[6] != od[6]) m_pend[3] = nw[6];
         if (nw[0] != od[0]) m_tb = nw[0];
         if (od[4] && !nw[4]) m_stop = 1'b1;
         if (od[5] && !nw[5]) m_req = 1'b1;
      end
   end

   task automatic chk(input string tag, input string what,
                      input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
      end
   endtask

   // compare one time unit after every rising edge
   always @(posedge clk) begin
      #1;
      if (!rst_n) begin
         chk("R1", "reset pending", pending, 4'h0);
         chk("R1", "reset outputs", {hard_irq, tb_run, core_stop, sys_reset_req},
             4'b0100);
      end else begin
         chk("R2", "tb_run", {3'b0, tb_run}, {3'b0, m_tb});
         chk("R3", "ext/smi bits", {2'b0, pending[1:0]}, {2'b0, m_pend[1:0]});
         chk("R4", "mchk bit", {3'b0, pending[2]}, {3'b0, m_pend[2]});
         chk("R5", "core_stop", {3'b0, core_stop}, {3'b0, m_stop});
         chk("R6", "sys_reset_req", {3'b0, sys_reset_req}, {3'b0, m_req});
         chk("R7", "sreset bit", {3'b0, pending[3]}, {3'b0, m_pend[3]});
         chk("R8", "hard_irq", {3'b0, hard_irq}, {3'b0, |m_pend});
         chk("R9_R10", "full vector", pending, m_pend);
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; checks++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2468;
      cyc(5);
      rst_n = 1'b1;
      // R3/R7: slow toggles of level pins
      cyc(3); pins[1] = 1'b1; cyc(6); pins[1] = 1'b0; cyc(6);
      pins[2] = 1'b1; cyc(6); pins[6] = 1'b1; cyc(6);
      pins[2] = 1'b0; cyc(4); pins[6] = 1'b0; cyc(6);
      // R9: acknowledge while the pin stays high, bit must stay clear
      pins[1] = 1'b1; cyc(6); ack = 4'b0001; cyc(1); ack = '0; cyc(8);
      pins[1] = 1'b0; cyc(6);
      // R4: machine-check falls, rise keeps it, ack clears
      pins[3] = 1'b1; cyc(6); pins[3] = 1'b0; cyc(6); pins[3] = 1'b1; cyc(6);
      ack = 4'b0100; cyc(1); ack = '0; cyc(6);
      // R9: ack at the same edge as a fall event - event wins
      pins[3] = 1'b0; cyc(2); ack = 4'b0100; cyc(1); ack = '0; cyc(6);
      ack = 4'b0100; cyc(1); ack = '0; cyc(4);
      // R10: single-cycle glitches
      pins[3] = 1'b1; cyc(1); pins[3] = 1'b0; cyc(6);
      pins[1] = 1'b1; cyc(1); pins[1] = 1'b0; cyc(6);
      // R2: freeze and restart the time base
      pins[0] = 1'b0; cyc(7); pins[0] = 1'b1; cyc(1); pins[0] = 1'b0; cyc(5);
      pins[0] = 1'b1; cyc(6);
      // R6/R10: held-low hard reset gives one pulse; glitches
      pins[5] = 1'b0; cyc(10); pins[5] = 1'b1; cyc(6);
      pins[5] = 1'b0; cyc(1); pins[5] = 1'b1; cyc(1); pins[5] = 1'b0; cyc(1);
      pins[5] = 1'b1; cyc(6);
      // random phase with checkstop idle
      for (int i = 0; i < 600; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[2:0] == 3'd0) pins[lfsr[5:3] % 7] ^= 1'b1;
         pins[4] = 1'b1;
         ack = (lfsr[9:7] == 3'd0) ? lfsr[13:10] : 4'h0;
         cyc(1);
      end
      ack = '0; pins = IDLE; cyc(6);
      // R5: checkstop stops; releasing the pin does not restart
      pins[4] = 1'b0; cyc(6); pins[4] = 1'b1; cyc(10);
      pins[4] = 1'b0; cyc(3); pins[4] = 1'b1; cyc(6);
      // random phase including checkstop
      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         if (lfsr[1:0] == 2'd0) pins[lfsr[5:3] % 7] ^= 1'b1;
         ack = (lfsr[8:6] == 3'd1) ? lfsr[12:9] : 4'h0;
         cyc(1);
      end
      // R1: mid-run reset releases the stop and clears state
      rst_n = 1'b0; ack = '0; cyc(4); pins = IDLE; cyc(2);
      rst_n = 1'b1; cyc(8);
      // R5: after reset, a low checkstop at release is caught
      pins[4] = 1'b0; pins[1] = 1'b1; cyc(8);
      done = 1'b1;
      finish_run();
   end

endmodule